// File: doc/BRIEF.md
# Atomic Double-Width Compare-and-Swap Unit

This block performs one indivisible compare-and-swap on a memory operand twice the width of a register half. A caller presents an expected value and a replacement value, each as a pair of high and low halves, together with a byte address and a width select. The unit reads the memory word under a bus lock and compares it with the expected pair. It then always issues a write under the same lock. On a match the write carries the replacement pair. On a mismatch it carries the word just read, so memory is left unchanged. Holding the lock across both cycles means no other agent can come between the read and the write.

Two operand widths are supported. The narrow mode works on 64 bits built from two 32-bit halves. The wide mode works on 128 bits built from two 64-bit halves. The unit returns the updated expected pair, a status-flag vector in which only the zero flag is recomputed, and a two-bit fault code. Faults are checked before any memory access: a register destination, a misaligned wide operand, and a misaligned narrow operand when alignment checking applies at privilege level 3. A one-cycle done pulse closes every operation, whether it completed or faulted.

Top module: `pair_cas_unit`

## Requirements
- R1: Narrow mode (`wide_i`=0). The compared value is {exp_hi_i[31:0], exp_lo_i[31:0]} against memory bits [63:0], and the replacement is {new_hi_i[31:0], new_lo_i[31:0]}. Input bits above 31 are ignored. Bits [127:64] of `wr_data_o` and bits [63:32] of both expected outputs are driven zero.
- R2: Wide mode (`wide_i`=1). The compared value is {exp_hi_i, exp_lo_i} against all 128 memory bits, and the replacement is {new_hi_i, new_lo_i}. The high input always forms the upper half.
- R3: On a match, flag bit 3 (zero) is set to 1, the replacement is written, and the expected outputs return the compared value split into halves.
- R4: On a mismatch, flag bit 3 is cleared to 0, the expected outputs return the memory value split into halves, and the value read is written back to the same address unchanged.
- R5: A non-faulting operation makes exactly one read handshake followed by exactly one write handshake. `mem_lock_o` is high from the read request until the write is accepted. Address and write data hold while a request waits for ready.
- R6: In wide mode, an address with bits [3:0] not all zero gives fault code 2 (general protection) and no memory access.
- R7: `reg_dest_i`=1 gives fault code 1 (invalid opcode) and no memory access. This fault takes priority over every other fault.
- R8: In narrow mode, when `align_chk_i`=1, `cpl_i`=3 and address bits [2:0] are not all zero, the fault code is 3 (alignment check). Any other privilege level, or alignment checking off, lets the operation proceed.
- R9: Flag bits 0, 1, 2, 4 and 5 (carry, parity, auxiliary, sign, overflow) are copied from `flags_i`. A faulting operation never raises the lock and leaves `exp_hi_o`, `exp_lo_o` and `flags_o` unchanged.
- R10: `done_o` is high for exactly one cycle per operation, and `fault_o` is valid with it (0 = no fault). Operands are captured at start. A start request outside the idle state is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken only when idle |
| wide_i | input | 1 | 1 = 128-bit operand, 0 = 64-bit operand |
| reg_dest_i | input | 1 | Destination is a register, not memory |
| align_chk_i | input | 1 | Alignment checking enabled |
| cpl_i | input | 2 | Current privilege level |
| addr_i | input | 48 | Byte address of the operand |
| exp_hi_i | input | 64 | Expected value, high half |
| exp_lo_i | input | 64 | Expected value, low half |
| new_hi_i | input | 64 | Replacement value, high half |
| new_lo_i | input | 64 | Replacement value, low half |
| flags_i | input | 6 | Incoming status flags (bit 3 = zero) |
| mem_lock_o | output | 1 | Bus lock for the read-write pair |
| mem_addr_o | output | 48 | Memory address |
| mem_wide_o | output | 1 | Access width, 1 = 128 bits |
| rd_valid_o | output | 1 | Read request |
| rd_ready_i | input | 1 | Read accepted; `rd_data_i` valid this cycle |
| rd_data_i | input | 128 | Read data |
| wr_valid_o | output | 1 | Write request |
| wr_ready_i | input | 1 | Write accepted |
| wr_data_o | output | 128 | Write data |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 2 | Fault code: 0 none, 1 invalid opcode, 2 general protection, 3 alignment check |
| exp_hi_o | output | 64 | Updated expected value, high half |
| exp_lo_o | output | 64 | Updated expected value, low half |
| flags_o | output | 6 | Updated status flags |

## Verification
The compare-and-swap is driven with exact matches in both widths, and with mismatches confined to the high half alone or the low half alone. These show whether both halves take part in the comparison and in the right order. Narrow cases carry junk in the upper input bits, which separates correct 32-bit packing from a full-width compare. Unaligned addresses are run at several privilege levels, with alignment checking both on and off, and combined with a register destination; this separates the three faults and their priority from a proceeding operation. Memory ready is stalled with different patterns, a start is pulsed while the unit is busy, and the operands are changed after start, so that lock coverage and operand capture are tested apart from the data path.

// File: rtl/pcas_pkg.sv
package pcas_pkg;
   localparam int FLAG_W = 6;
   localparam int ZF_POS = 3;

   typedef enum logic [2:0] {
      ST_IDLE, ST_CHECK, ST_READ, ST_COMPARE, ST_WRITE, ST_DONE
   } pcas_state_e;

   typedef enum logic [1:0] {
      FLT_NONE = 2'd0,
      FLT_UD   = 2'd1,
      FLT_GP   = 2'd2,
      FLT_AC   = 2'd3
   } pcas_fault_e;
endpackage

// File: rtl/pcas_fault_chk.sv
module pcas_fault_chk import pcas_pkg::*; #(
   parameter int ADDR_W       = 48,
   parameter int WIDE_BYTES   = 16,
   parameter int NARROW_BYTES = 8
) (
   input  logic              reg_dest_i,
   input  logic              wide_i,
   input  logic              align_chk_i,
   input  logic [1:0]        cpl_i,
   input  logic [ADDR_W-1:0] addr_i,
   output pcas_fault_e       code_o
);
   localparam int WIDE_LSB = $clog2(WIDE_BYTES);
   localparam int NAR_LSB  = $clog2(NARROW_BYTES);

   generate
      if (WIDE_LSB < 1 || NAR_LSB < 1 || WIDE_LSB > ADDR_W) begin : g_bad_geom
         $error("pcas_fault_chk: operand sizes do not fit the address width");
      end
   endgenerate

   logic wide_mis, nar_mis;
   assign wide_mis = |addr_i[WIDE_LSB-1:0];
   assign nar_mis  = |addr_i[NAR_LSB-1:0];

   always_comb begin
      if (reg_dest_i)                                         code_o = FLT_UD;
      else if (wide_i && wide_mis)                            code_o = FLT_GP;
      else if (!wide_i && nar_mis && align_chk_i && cpl_i == 2'd3) code_o = FLT_AC;
      else                                                    code_o = FLT_NONE;
   end
endmodule

// File: rtl/pcas_pair_pack.sv
module pcas_pair_pack #(
   parameter int HALF_W   = 64,
   parameter int NARROW_W = 32
) (
   input  logic                wide_i,
   input  logic [HALF_W-1:0]   hi_i,
   input  logic [HALF_W-1:0]   lo_i,
   output logic [2*HALF_W-1:0] word_o
);
   localparam int PAD = 2*HALF_W - 2*NARROW_W;

   generate
      if (NARROW_W >= HALF_W || NARROW_W < 8) begin : g_bad_width
         $error("pcas_pair_pack: narrow half must be narrower than the wide half");
      end
   endgenerate

   assign word_o = wide_i ? {hi_i, lo_i}
                          : {{PAD{1'b0}}, hi_i[NARROW_W-1:0], lo_i[NARROW_W-1:0]};
endmodule

// File: rtl/pcas_pair_split.sv
module pcas_pair_split #(
   parameter int HALF_W   = 64,
   parameter int NARROW_W = 32
) (
   input  logic                wide_i,
   input  logic [2*HALF_W-1:0] word_i,
   output logic [HALF_W-1:0]   hi_o,
   output logic [HALF_W-1:0]   lo_o
);
   localparam int HPAD = HALF_W - NARROW_W;

   always_comb begin
      if (wide_i) begin
         hi_o = word_i[2*HALF_W-1:HALF_W];
         lo_o = word_i[HALF_W-1:0];
      end else begin
         hi_o = {{HPAD{1'b0}}, word_i[2*NARROW_W-1:NARROW_W]};
         lo_o = {{HPAD{1'b0}}, word_i[NARROW_W-1:0]};
      end
   end
endmodule

// File: rtl/pair_cas_unit.sv
module pair_cas_unit import pcas_pkg::*; #(
   parameter int HALF_W   = 64,
   parameter int NARROW_W = 32,
   parameter int ADDR_W   = 48
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_i,
   input  logic                wide_i,
   input  logic                reg_dest_i,
   input  logic                align_chk_i,
   input  logic [1:0]          cpl_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [HALF_W-1:0]   exp_hi_i,
   input  logic [HALF_W-1:0]   exp_lo_i,
   input  logic [HALF_W-1:0]   new_hi_i,
   input  logic [HALF_W-1:0]   new_lo_i,
   input  logic [FLAG_W-1:0]   flags_i,
   output logic                mem_lock_o,
   output logic [ADDR_W-1:0]   mem_addr_o,
   output logic                mem_wide_o,
   output logic                rd_valid_o,
   input  logic                rd_ready_i,
   input  logic [2*HALF_W-1:0] rd_data_i,
   output logic                wr_valid_o,
   input  logic                wr_ready_i,
   output logic [2*HALF_W-1:0] wr_data_o,
   output logic                done_o,
   output logic [1:0]          fault_o,
   output logic [HALF_W-1:0]   exp_hi_o,
   output logic [HALF_W-1:0]   exp_lo_o,
   output logic [FLAG_W-1:0]   flags_o
);
   localparam int DW           = 2*HALF_W;
   localparam int WIDE_BYTES   = DW/8;
   localparam int NARROW_BYTES = 2*NARROW_W/8;
   localparam logic [DW-1:0] NARROW_MASK = {{(DW-2*NARROW_W){1'b0}}, {(2*NARROW_W){1'b1}}};

   generate
      if (HALF_W % 8 != 0 || NARROW_W % 8 != 0) begin : g_bad_bytes
         $error("pair_cas_unit: halves must be whole bytes");
      end
   endgenerate

   pcas_state_e       state;
   pcas_fault_e       fault_q, chk_code;
   logic              op_wide, op_reg_dest, op_align, hit_q;
   logic [1:0]        op_cpl;
   logic [ADDR_W-1:0] op_addr;
   logic [HALF_W-1:0] op_exp_hi, op_exp_lo, op_new_hi, op_new_lo;
   logic [HALF_W-1:0] exp_hi_q, exp_lo_q, res_hi, res_lo;
   logic [FLAG_W-1:0] op_flags, flags_q, flags_next;
   logic [DW-1:0]     rd_word, wr_word, exp_word, new_word, res_word;

   pcas_fault_chk #(.ADDR_W(ADDR_W), .WIDE_BYTES(WIDE_BYTES), .NARROW_BYTES(NARROW_BYTES)) u_fault (
      .reg_dest_i(op_reg_dest), .wide_i(op_wide), .align_chk_i(op_align),
      .cpl_i(op_cpl), .addr_i(op_addr), .code_o(chk_code));

   pcas_pair_pack #(.HALF_W(HALF_W), .NARROW_W(NARROW_W)) u_pack_exp (
      .wide_i(op_wide), .hi_i(op_exp_hi), .lo_i(op_exp_lo), .word_o(exp_word));

   pcas_pair_pack #(.HALF_W(HALF_W), .NARROW_W(NARROW_W)) u_pack_new (
      .wide_i(op_wide), .hi_i(op_new_hi), .lo_i(op_new_lo), .word_o(new_word));

   assign res_word = hit_q ? exp_word : rd_word;

   pcas_pair_split #(.HALF_W(HALF_W), .NARROW_W(NARROW_W)) u_split (
      .wide_i(op_wide), .word_i(res_word), .hi_o(res_hi), .lo_o(res_lo));

   always_comb begin
      flags_next         = op_flags;
      flags_next[ZF_POS] = hit_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         fault_q     <= FLT_NONE;
         op_wide     <= 1'b0;
         op_reg_dest <= 1'b0;
         op_align    <= 1'b0;
         op_cpl      <= '0;
         op_addr     <= '0;
         op_exp_hi   <= '0;
         op_exp_lo   <= '0;
         op_new_hi   <= '0;
         op_new_lo   <= '0;
         op_flags    <= '0;
         hit_q       <= 1'b0;
         rd_word     <= '0;
         wr_word     <= '0;
         exp_hi_q    <= '0;
         exp_lo_q    <= '0;
         flags_q     <= '0;
      end else begin
         case (state)
            ST_IDLE: if (start_i) begin
               op_wide     <= wide_i;
               op_reg_dest <= reg_dest_i;
               op_align    <= align_chk_i;
               op_cpl      <= cpl_i;
               op_addr     <= addr_i;
               op_exp_hi   <= exp_hi_i;
               op_exp_lo   <= exp_lo_i;
               op_new_hi   <= new_hi_i;
               op_new_lo   <= new_lo_i;
               op_flags    <= flags_i;
               state       <= ST_CHECK;
            end
            ST_CHECK: begin
               fault_q <= chk_code;
               state   <= (chk_code == FLT_NONE) ? ST_READ : ST_DONE;
            end
            ST_READ: if (rd_ready_i) begin
               rd_word <= op_wide ? rd_data_i : (rd_data_i & NARROW_MASK);
               state   <= ST_COMPARE;
            end
            ST_COMPARE: begin
               hit_q   <= (exp_word == rd_word);
               wr_word <= (exp_word == rd_word) ? new_word : rd_word;
               state   <= ST_WRITE;
            end
            ST_WRITE: if (wr_ready_i) begin
               exp_hi_q <= res_hi;
               exp_lo_q <= res_lo;
               flags_q  <= flags_next;
               state    <= ST_DONE;
            end
            ST_DONE:  state <= ST_IDLE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   assign mem_lock_o = (state == ST_READ) || (state == ST_COMPARE) || (state == ST_WRITE);
   assign rd_valid_o = (state == ST_READ);
   assign wr_valid_o = (state == ST_WRITE);
   assign mem_addr_o = op_addr;
   assign mem_wide_o = op_wide;
   assign wr_data_o  = wr_word;
   assign done_o     = (state == ST_DONE);
   assign fault_o    = fault_q;
   assign exp_hi_o   = exp_hi_q;
   assign exp_lo_o   = exp_lo_q;
   assign flags_o    = flags_q;
endmodule

// File: rtl/pcas_unit_chk.sv
module pcas_unit_chk #(
   parameter int HALF_W   = 64,
   parameter int NARROW_W = 32,
   parameter int ADDR_W   = 48,
   parameter int FLAG_W   = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                mem_lock_o,
   input logic [ADDR_W-1:0]   mem_addr_o,
   input logic                mem_wide_o,
   input logic                rd_valid_o,
   input logic                rd_ready_i,
   input logic                wr_valid_o,
   input logic                wr_ready_i,
   input logic [2*HALF_W-1:0] wr_data_o,
   input logic                done_o,
   input logic [1:0]          fault_o,
   input logic [HALF_W-1:0]   exp_hi_o,
   input logic [HALF_W-1:0]   exp_lo_o,
   input logic [FLAG_W-1:0]   flags_o
);
   localparam int DW = 2*HALF_W;

   assert_rd_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o |-> mem_lock_o);

   assert_wr_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o |-> mem_lock_o);

   assert_wr_follows_locked_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_valid_o) |-> $past(mem_lock_o));

   assert_rd_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(mem_addr_o));

   assert_wr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o && !wr_ready_i |=> wr_valid_o && $stable(wr_data_o) && $stable(mem_addr_o));

   assert_lock_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o && wr_ready_i |=> !mem_lock_o && done_o);

   assert_narrow_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid_o && !mem_wide_o |-> wr_data_o[DW-1:2*NARROW_W] == '0);

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_fault_keeps_regs_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && fault_o != 2'd0 |-> $stable(exp_hi_o) && $stable(exp_lo_o) && $stable(flags_o));

   assert_fault_no_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && fault_o != 2'd0 |-> !$past(mem_lock_o));

   assert_gp_wide_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && fault_o == 2'd2 |-> mem_wide_o);

   assert_ac_narrow_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done_o && fault_o == 2'd3 |-> !mem_wide_o);
endmodule

bind pair_cas_unit pcas_unit_chk #(
   .HALF_W(HALF_W), .NARROW_W(NARROW_W), .ADDR_W(ADDR_W), .FLAG_W(pcas_pkg::FLAG_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_lock_o(mem_lock_o), .mem_addr_o(mem_addr_o),
   .mem_wide_o(mem_wide_o), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i),
   .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i), .wr_data_o(wr_data_o),
   .done_o(done_o), .fault_o(fault_o), .exp_hi_o(exp_hi_o), .exp_lo_o(exp_lo_o),
   .flags_o(flags_o)
);

// File: tb/tb_pair_cas_unit.sv
`timescale 1ns/1ps
module tb_pair_cas_unit;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0, wide_i = 1'b0, reg_dest_i = 1'b0, align_chk_i = 1'b0;
   logic [1:0]   cpl_i = '0;
   logic [47:0]  addr_i = '0;
   logic [63:0]  exp_hi_i = '0, exp_lo_i = '0, new_hi_i = '0, new_lo_i = '0;
   logic [5:0]   flags_i = '0;
   logic         mem_lock_o, mem_wide_o, rd_valid_o, wr_valid_o, done_o;
   logic [47:0]  mem_addr_o;
   logic         rd_ready_i = 1'b0, wr_ready_i = 1'b0;
   logic [127:0] rd_data_i = '0;
   logic [127:0] wr_data_o;
   logic [1:0]   fault_o;
   logic [63:0]  exp_hi_o, exp_lo_o;
   logic [5:0]   flags_o;

   always #2.5 clk = ~clk;

   pair_cas_unit dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_i), .reg_dest_i(reg_dest_i),
      .align_chk_i(align_chk_i), .cpl_i(cpl_i), .addr_i(addr_i),
      .exp_hi_i(exp_hi_i), .exp_lo_i(exp_lo_i), .new_hi_i(new_hi_i), .new_lo_i(new_lo_i),
      .flags_i(flags_i), .mem_lock_o(mem_lock_o), .mem_addr_o(mem_addr_o),
      .mem_wide_o(mem_wide_o), .rd_valid_o(rd_valid_o), .rd_ready_i(rd_ready_i),
      .rd_data_i(rd_data_i), .wr_valid_o(wr_valid_o), .wr_ready_i(wr_ready_i),
      .wr_data_o(wr_data_o), .done_o(done_o), .fault_o(fault_o),
      .exp_hi_o(exp_hi_o), .exp_lo_o(exp_lo_o), .flags_o(flags_o));

   // behavioural memory and bookkeeping
   logic [127:0] mem [logic [47:0]];
   int n_vec = 0, n_err = 0;
   int n_rd = 0, n_wr = 0, n_done = 0;
   int stall_mod = 1;
   int cyc = 0;
   bit busy = 0, fault_op = 0, lock_seen = 0;

   // model copies of the outputs held across operations
   logic [63:0] m_hi = '0, m_lo = '0;
   logic [5:0]  m_flags = '0;

   task automatic chk(input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // memory responder and per-cycle protocol comparison, all at the falling edge
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         rd_ready_i = (cyc % stall_mod) == 0;
         wr_ready_i = ((cyc + 1) % stall_mod) == 0;
         rd_data_i  = mem.exists(mem_addr_o) ? mem[mem_addr_o] : '0;
         if (rst_n) begin
            if (rd_valid_o && rd_ready_i) n_rd++;
            if (wr_valid_o && wr_ready_i) begin
               n_wr++;
               mem[mem_addr_o] = wr_data_o;
            end
            if (done_o) n_done++;
            if (mem_lock_o) lock_seen = 1;
            if (busy) begin
               chk("R5", "lock covers request", {127'b0, mem_lock_o},
                   {127'b0, mem_lock_o | rd_valid_o | wr_valid_o});
               if (fault_op) chk("R9", "no lock on faulting op", {127'b0, mem_lock_o}, '0);
            end
         end
      end
   end

   function automatic logic [127:0] pack(input bit wide, input logic [63:0] hi, input logic [63:0] lo);
      return wide ? {hi, lo} : {64'b0, hi[31:0], lo[31:0]};
   endfunction

   task automatic run_op(input string tag, input bit rdst, input bit wide, input bit achk,
                         input logic [1:0] cpl, input logic [47:0] addr,
                         input logic [63:0] ehi, input logic [63:0] elo,
                         input logic [63:0] nhi, input logic [63:0] nlo,
                         input logic [5:0] flg, input int stall, input bit poke);
      logic [1:0]   e_fault;
      logic [127:0] m_before, rdw, ew, nw, resw, m_after;
      bit           hit;
      int           rd0, wr0, dn0, waited;
      e_fault = rdst ? 2'd1 :
                (wide && addr[3:0] != 0) ? 2'd2 :
                (!wide && achk && cpl == 2'd3 && addr[2:0] != 0) ? 2'd3 : 2'd0;
      m_before = mem.exists(addr) ? mem[addr] : '0;
      rdw  = wide ? m_before : {64'b0, m_before[63:0]};
      ew   = pack(wide, ehi, elo);
      nw   = pack(wide, nhi, nlo);
      hit  = (ew == rdw);
      resw = hit ? ew : rdw;
      if (e_fault == 2'd0) begin
         m_hi    = wide ? resw[127:64] : {32'b0, resw[63:32]};
         m_lo    = wide ? resw[63:0]   : {32'b0, resw[31:0]};
         m_flags = flg;
         m_flags[3] = hit;
         m_after = hit ? nw : rdw;
      end else begin
         m_after = m_before;
      end
      stall_mod = stall;
      rd0 = n_rd; wr0 = n_wr; dn0 = n_done;
      @(negedge clk);
      busy = 1; fault_op = (e_fault != 0); lock_seen = 0;
      start_i = 1; reg_dest_i = rdst; wide_i = wide; align_chk_i = achk; cpl_i = cpl;
      addr_i = addr; exp_hi_i = ehi; exp_lo_i = elo; new_hi_i = nhi; new_lo_i = nlo; flags_i = flg;
      @(negedge clk);
      // operands changed after start must not matter (R10)
      start_i = 0; exp_hi_i = ~ehi; exp_lo_i = ~elo; new_hi_i = ~nhi; new_lo_i = ~nlo;
      flags_i = ~flg; addr_i = addr ^ 48'h40; wide_i = ~wide;
      waited = 0;
      while (!done_o && waited < 100) begin
         if (poke && waited == 1) start_i = 1;
         else start_i = 0;
         @(negedge clk);
         waited++;
      end
      start_i = 0;
      if (waited >= 100) chk("R10", {tag, " done timeout"}, 128'd0, 128'd1);
      chk("R10", {tag, " fault code"}, {126'b0, fault_o}, {126'b0, e_fault});
      chk(e_fault == 0 ? (hit ? "R3" : "R4") : "R9", {tag, " exp_hi"}, {64'b0, exp_hi_o}, {64'b0, m_hi});
      chk(e_fault == 0 ? (hit ? "R3" : "R4") : "R9", {tag, " exp_lo"}, {64'b0, exp_lo_o}, {64'b0, m_lo});
      chk("R9", {tag, " flags"}, {122'b0, flags_o}, {122'b0, m_flags});
      @(negedge clk);
      chk("R10", {tag, " done one cycle"}, {127'b0, done_o}, '0);
      chk(wide ? "R2" : "R1", {tag, " memory after"}, mem.exists(addr) ? mem[addr] : '0, m_after);
      chk("R5", {tag, " reads"}, n_rd - rd0, (e_fault == 0) ? 1 : 0);
      chk("R5", {tag, " writes"}, n_wr - wr0, (e_fault == 0) ? 1 : 0);
      chk("R10", {tag, " done count"}, n_done - dn0, 1);
      if (e_fault != 0) chk("R9", {tag, " lock never raised"}, {127'b0, lock_seen}, '0);
      busy = 0; fault_op = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_err++;
      $display("FAIL R10 watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end

   initial begin
      mem[48'h100] = 128'hA5A5A5A5_5A5A5A5A_11223344_55667788;
      mem[48'h200] = 128'h01234567_89ABCDEF_FEDCBA98_76543210;
      mem[48'h104] = 128'h0;
      mem[48'h10C] = 128'h0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R10", "reset done", {127'b0, done_o}, '0);
      chk("R5",  "reset lock", {127'b0, mem_lock_o}, '0);
      chk("R10", "reset fault", {126'b0, fault_o}, '0);
      chk("R9",  "reset outputs", {exp_hi_o, exp_lo_o}, '0);
      chk("R9",  "reset flags", {122'b0, flags_o}, '0);

      // R1/R3: narrow match with junk in upper input bits; upper memory half is cleared on write
      run_op("R1 narrow hit", 0, 0, 0, 2'd0, 48'h100, 64'hAAAA0000_11223344, 64'hBBBB0000_55667788,
             64'hFFFFFFFF_CAFEF00D, 64'h12345678_DEADBEEF, 6'b110111, 1, 0);
      // R4: narrow mismatch, value written back, stalled ready
      run_op("R4 narrow miss", 0, 0, 0, 2'd0, 48'h100, 64'h0, 64'h55667788,
             64'h1, 64'h2, 6'b001000, 3, 0);
      // R2/R3: wide match
      run_op("R2 wide hit", 0, 1, 1, 2'd3, 48'h200, 64'h01234567_89ABCDEF, 64'hFEDCBA98_76543210,
             64'h11111111_22222222, 64'h33333333_44444444, 6'b101010, 2, 0);
      // R4: wide mismatch in the low half only
      run_op("R4 wide low diff", 0, 1, 0, 2'd0, 48'h200, 64'h11111111_22222222, 64'h33333333_44444445,
             64'h9, 64'h9, 6'b010101, 1, 0);
      // R4: wide mismatch in the high half only
      run_op("R4 wide high diff", 0, 1, 0, 2'd0, 48'h200, 64'h11111111_22222223, 64'h33333333_44444444,
             64'h9, 64'h9, 6'b111111, 4, 0);
      // R7: register destination wins over a misaligned wide address
      run_op("R7 reg dest", 1, 1, 1, 2'd3, 48'h208, 64'h0, 64'h0, 64'h0, 64'h0, 6'b000001, 1, 0);
      // R6: misaligned wide address
      run_op("R6 wide misaligned", 0, 1, 0, 2'd0, 48'h208, 64'h0, 64'h0, 64'h0, 64'h0, 6'b000010, 1, 0);
      // R8: narrow misaligned, checking on, privilege 3
      run_op("R8 ac fault", 0, 0, 1, 2'd3, 48'h104, 64'h0, 64'h0, 64'h5, 64'h6, 6'b000100, 1, 0);
      // R8: same address at privilege 0 proceeds (match on zero memory)
      run_op("R8 cpl0 proceeds", 0, 0, 1, 2'd0, 48'h104, 64'h0, 64'h0, 64'h5, 64'h6, 6'b100000, 2, 0);
      // R8: checking off at privilege 3 proceeds
      run_op("R8 chk off proceeds", 0, 0, 0, 2'd3, 48'h10C, 64'h1, 64'h0, 64'h7, 64'h8, 6'b011000, 1, 0);
      // R10: start pulsed while busy is ignored
      run_op("R10 busy start", 0, 1, 0, 2'd0, 48'h200, 64'h11111111_22222222, 64'h33333333_44444444,
             64'hABCD, 64'hEF01, 6'b000000, 5, 1);
      // R7: register destination on a clean narrow request
      run_op("R7 reg dest narrow", 1, 0, 0, 2'd0, 48'h100, 64'h0, 64'h0, 64'h0, 64'h0, 6'b111000, 1, 0);

      repeat (3) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
      $finish;
   end
endmodule